// File: doc/BRIEF.md
# Packed Absolute-Difference Accumulate Unit

This block is a packed-integer vector datapath. It takes two source vectors and one accumulator vector. For every lane it forms the exact difference of the two source elements and takes its magnitude. It adds that magnitude into the matching accumulator lane. Three run-time controls set the lanes: a 2-bit size code picks the lane width, one bit picks unsigned or two's-complement elements, and one bit picks a 64-bit or a 128-bit vector.

The caller also passes the destination and source register indices. The unit flags control combinations that are not allowed and then returns the accumulator unchanged. The result and the flag appear one cycle after `validIn`, whatever the data values are. The block holds no register file. The surrounding pipeline supplies the operands and writes the result back.

Top module: `absdiff_acc_unit`

## Requirements
- R1: The lane width is 8 << sizeCode. sizeCode 0, 1 and 2 give 8-, 16- and 32-bit lanes. Lane k of every vector is bits [k*W+W-1 : k*W].
- R2: When sizeCode is 3, undefOut is 1 and accOut equals accIn, masked to the active vector width.
- R3: With isUnsigned = 1, both source elements are read as unsigned integers. With isUnsigned = 0, both are read as two's-complement integers.
- R4: With wideMode = 0, only bits [63:0] are processed (64/W lanes) and accOut[127:64] is 0. With wideMode = 1, all 128 bits are processed (128/W lanes).
- R5: With wideMode = 1, a value of 1 in bit 0 of dstIdx, srcAIdx or srcBIdx sets undefOut and passes the accumulator through unchanged. With wideMode = 0, odd indices are legal.
- R6: The difference is exact before its magnitude is taken. For example, signed 8-bit -128 and 127 give a magnitude of 255.
- R7: Each result lane is (accumulator lane + magnitude) mod 2^W. There is no saturation.
- R8: validOut is 1 exactly one cycle after validIn is 1, and 0 otherwise. A synchronous active-high rst clears validOut, undefOut and accOut.
- R9: In a cycle with validIn = 0, accOut and undefOut keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| validIn | input | 1 | Operation request |
| sizeCode | input | 2 | Lane width code |
| isUnsigned | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| wideMode | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| dstIdx | input | 5 | Destination register index |
| srcAIdx | input | 5 | First source register index |
| srcBIdx | input | 5 | Second source register index |
| srcA | input | 128 | Minuend vector |
| srcB | input | 128 | Subtrahend vector |
| accIn | input | 128 | Accumulator vector |
| validOut | output | 1 | Result valid |
| undefOut | output | 1 | Illegal control combination flagged |
| accOut | output | 128 | Accumulated result |

## Verification
In a single cycle the unit can both decide that an operation is illegal and still compute lane sums from valid-looking data. The bench provokes this by sending a wide operation with an odd index, or with size code 3, while the sources and accumulator hold values that would change the result. It judges the outcome by requiring the flag and the unchanged accumulator on the next cycle. The bench also sends back-to-back operations whose legality alternates. Each result then has to match its own request, with no leftover flag or data from the request before it.

// File: rtl/absacc_pkg.sv
package absacc_pkg;
  localparam int VEC_W  = 128;
  localparam int HALF_W = VEC_W / 2;
  localparam int IDX_W  = 5;
  localparam int SZ_W   = 2;

  typedef struct packed {
    logic          load;
    logic          passThru;
    logic          wide;
    logic [SZ_W-1:0] sizeSel;
  } absacc_ctrl_t;
endpackage

// File: rtl/absacc_ctrl.sv
module absacc_ctrl
  import absacc_pkg::*;
#(
  parameter int IDX_BITS = IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                validIn,
  input  logic [SZ_W-1:0]     sizeCode,
  input  logic                wideMode,
  input  logic [IDX_BITS-1:0] dstIdx,
  input  logic [IDX_BITS-1:0] srcAIdx,
  input  logic [IDX_BITS-1:0] srcBIdx,
  output absacc_ctrl_t        strobe,
  output logic                validOut,
  output logic                undefOut
);
  logic badSize;
  logic badAlign;
  logic illegal;

  always_comb begin
    badSize  = (sizeCode == 2'b11);
    badAlign = wideMode && (dstIdx[0] || srcAIdx[0] || srcBIdx[0]);
    illegal  = badSize || badAlign;
    strobe.load     = validIn;
    strobe.passThru = illegal;
    strobe.wide     = wideMode;
    strobe.sizeSel  = sizeCode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validOut <= 1'b0;
      undefOut <= 1'b0;
    end else begin
      validOut <= validIn;
      if (validIn) undefOut <= illegal;
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> !validOut);
  // R2
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (validIn && sizeCode == 2'b11) |=> undefOut);
  // R5
  bad_align_chk: assert property (@(posedge clk) disable iff (rst)
    (validIn && wideMode && (dstIdx[0] || srcAIdx[0] || srcBIdx[0])) |=> undefOut);
  // R9
  undef_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> $stable(undefOut));
endmodule

// File: rtl/absacc_dp.sv
module absacc_dp
  import absacc_pkg::*;
#(
  parameter int DATA_W = VEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  absacc_ctrl_t      strobe,
  input  logic              unsSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] accIn,
  output logic [DATA_W-1:0] accOut
);
  localparam int LOW_W  = DATA_W / 2;
  localparam int N_SIZE = 3;

  for (genvar g = 0; g < N_SIZE; g++) begin : gW
    localparam int W  = 8 << g;
    localparam int LN = DATA_W / W;
    logic [DATA_W-1:0] widthSum;
    for (genvar l = 0; l < LN; l++) begin : gL
      logic [W:0]   aX, bX, dX, negD;
      logic [W-1:0] mag;
      always_comb begin
        aX   = {~unsSel & srcA[l*W+W-1], srcA[l*W +: W]};
        bX   = {~unsSel & srcB[l*W+W-1], srcB[l*W +: W]};
        dX   = aX - bX;
        negD = (~dX) + 1'b1;
        mag  = dX[W] ? negD[W-1:0] : dX[W-1:0];
      end
      assign widthSum[l*W +: W] = accIn[l*W +: W] + mag;
    end
  end

  logic [DATA_W-1:0] sumSel;
  logic [DATA_W-1:0] nextVal;

  always_comb begin
    case (strobe.sizeSel)
      2'd0:    sumSel = gW[0].widthSum;
      2'd1:    sumSel = gW[1].widthSum;
      2'd2:    sumSel = gW[2].widthSum;
      default: sumSel = accIn;
    endcase
    nextVal = strobe.passThru ? accIn : sumSel;
    if (!strobe.wide) nextVal[DATA_W-1:LOW_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) accOut <= '0;
    else if (strobe.load) accOut <= nextVal;
  end

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(accOut));
  // R4
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && !strobe.wide) |=> (accOut[DATA_W-1:LOW_W] == '0));
  // R2
  pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.passThru && strobe.wide) |=> (accOut == $past(accIn)));
endmodule

// File: rtl/absdiff_acc_unit.sv
module absdiff_acc_unit
  import absacc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               validIn,
  input  logic [1:0]         sizeCode,
  input  logic               isUnsigned,
  input  logic               wideMode,
  input  logic [4:0]         dstIdx,
  input  logic [4:0]         srcAIdx,
  input  logic [4:0]         srcBIdx,
  input  logic [127:0]       srcA,
  input  logic [127:0]       srcB,
  input  logic [127:0]       accIn,
  output logic               validOut,
  output logic               undefOut,
  output logic [127:0]       accOut
);
  absacc_ctrl_t strobe;

  absacc_ctrl #(.IDX_BITS(IDX_W)) i_ctrl (
    .clk(clk), .rst(rst), .validIn(validIn), .sizeCode(sizeCode),
    .wideMode(wideMode), .dstIdx(dstIdx), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .strobe(strobe), .validOut(validOut), .undefOut(undefOut)
  );

  absacc_dp #(.DATA_W(VEC_W)) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .unsSel(isUnsigned),
    .srcA(srcA), .srcB(srcB), .accIn(accIn), .accOut(accOut)
  );
endmodule

// File: tb/test_absdiff_acc_unit.sv
module test_absdiff_acc_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         validIn;
  logic [1:0]   sizeCode;
  logic         isUnsigned, wideMode;
  logic [4:0]   dstIdx, srcAIdx, srcBIdx;
  logic [127:0] srcA, srcB, accIn;
  logic         validOut, undefOut;
  logic [127:0] accOut;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  absdiff_acc_unit i_absdiff_acc_unit (
    .clk(clk), .rst(rst), .validIn(validIn), .sizeCode(sizeCode),
    .isUnsigned(isUnsigned), .wideMode(wideMode), .dstIdx(dstIdx),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .srcA(srcA), .srcB(srcB),
    .accIn(accIn), .validOut(validOut), .undefOut(undefOut), .accOut(accOut)
  );

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] refAcc(input logic [1:0] sz, input logic uns,
      input logic wide, input logic bad, input logic [127:0] a, input logic [127:0] b,
      input logic [127:0] c);
    logic [127:0] r, mask, ta, tb, tc;
    int w, lanes;
    longint ea, eb, ec, d, s;
    if (bad) begin
      r = c;
      if (!wide) r[127:64] = '0;
      return r;
    end
    w = 8 << sz;
    lanes = (wide ? 128 : 64) / w;
    mask = (128'd1 << w) - 1;
    r = '0;
    for (int l = 0; l < lanes; l++) begin
      ta = (a >> (l*w)) & mask; tb = (b >> (l*w)) & mask; tc = (c >> (l*w)) & mask;
      ea = longint'(ta[63:0]); eb = longint'(tb[63:0]); ec = longint'(tc[63:0]);
      if (!uns && ea >= (64'sd1 <<< (w-1))) ea -= (64'sd1 <<< w);
      if (!uns && eb >= (64'sd1 <<< (w-1))) eb -= (64'sd1 <<< w);
      d = ea - eb;
      if (d < 0) d = -d;
      s = ec + d;
      r = r | (((128'(s)) & mask) << (l*w));
    end
    return r;
  endfunction

  task automatic runOp(input string req, input logic [1:0] sz, input logic uns,
      input logic wide, input logic [4:0] di, input logic [4:0] ai, input logic [4:0] bi,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    logic bad;
    logic [127:0] exp;
    bad = (sz == 2'b11) || (wide && (di[0] || ai[0] || bi[0]));
    exp = refAcc(sz, uns, wide, bad, a, b, c);
    @(negedge clk);
    validIn = 1'b1; sizeCode = sz; isUnsigned = uns; wideMode = wide;
    dstIdx = di; srcAIdx = ai; srcBIdx = bi; srcA = a; srcB = b; accIn = c;
    @(negedge clk);
    validIn = 1'b0;
    check({req, " valid"}, 128'(validOut), 128'd1);
    check({req, " undef"}, 128'(undefOut), 128'(bad));
    check({req, " acc"}, accOut, exp);
  endtask

  task automatic testReset();
    rst = 1'b1; validIn = 1'b0; sizeCode = 0; isUnsigned = 0; wideMode = 0;
    dstIdx = 0; srcAIdx = 0; srcBIdx = 0; srcA = '0; srcB = '0; accIn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 reset valid", 128'(validOut), 128'd0);
    check("R8 reset undef", 128'(undefOut), 128'd0);
    check("R8 reset acc", accOut, 128'd0);
  endtask

  // R1 R3 R4: every width, signedness and length with extremes
  task automatic testSweep();
    logic [127:0] a, b, c;
    for (int sz = 0; sz < 3; sz++)
      for (int u = 0; u < 2; u++)
        for (int wd = 0; wd < 2; wd++) begin
          a = {8{16'h7F80}}; b = {8{16'h807F}}; c = {4{32'h0123_89AB}};
          runOp("R1 R3 R4 extremes", 2'(sz), u[0], wd[0], 5'd2, 5'd4, 5'd6, a, b, c);
          a = {16{8'hFF}}; b = '0; c = {16{8'h01}};
          runOp("R3 max-min", 2'(sz), u[0], wd[0], 5'd0, 5'd8, 5'd10, a, b, c);
          for (int k = 0; k < 4; k++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            c = {$urandom, $urandom, $urandom, $urandom};
            runOp("R1 R4 pattern", 2'(sz), u[0], wd[0], 5'd12, 5'd14, 5'd16, a, b, c);
          end
        end
  endtask

  // R6: exact difference of signed extremes
  task automatic testExact();
    runOp("R6 s8 -128 vs 127", 2'd0, 1'b0, 1'b0, 5'd0, 5'd2, 5'd4,
          128'h80, 128'h7F, 128'h0);
    check("R6 lane0 is 255", 128'(accOut[7:0]), 128'd255);
    runOp("R6 s32 extremes", 2'd2, 1'b0, 1'b1, 5'd0, 5'd2, 5'd4,
          {4{32'h8000_0000}}, {4{32'h7FFF_FFFF}}, '0);
    check("R6 lane0 is 2^32-1", 128'(accOut[31:0]), 128'hFFFF_FFFF);
  endtask

  // R7: modular wraparound
  task automatic testWrap();
    runOp("R7 u8 wrap", 2'd0, 1'b1, 1'b0, 5'd1, 5'd3, 5'd5,
          128'h05, 128'h00, 128'hFE);
    check("R7 lane0 wraps to 3", 128'(accOut[7:0]), 128'h03);
    runOp("R7 u16 wrap", 2'd1, 1'b1, 1'b1, 5'd0, 5'd2, 5'd4,
          {8{16'hFFFF}}, '0, {8{16'h0002}});
    check("R7 lane7 wraps to 1", 128'(accOut[127:112]), 128'h0001);
  endtask

  // R2 R5: illegal controls with data that would change the result
  task automatic testIllegal();
    logic [127:0] a, b, c;
    a = {4{32'hDEAD_BEEF}}; b = {4{32'h1234_5678}}; c = {4{32'hCAFE_F00D}};
    runOp("R2 size code 3 narrow", 2'd3, 1'b0, 1'b0, 5'd0, 5'd2, 5'd4, a, b, c);
    runOp("R2 size code 3 wide", 2'd3, 1'b1, 1'b1, 5'd0, 5'd2, 5'd4, a, b, c);
    runOp("R5 odd dst wide", 2'd0, 1'b1, 1'b1, 5'd1, 5'd2, 5'd4, a, b, c);
    runOp("R5 odd srcA wide", 2'd1, 1'b0, 1'b1, 5'd0, 5'd3, 5'd4, a, b, c);
    runOp("R5 odd srcB wide", 2'd2, 1'b0, 1'b1, 5'd0, 5'd2, 5'd7, a, b, c);
    runOp("R5 odd ok narrow", 2'd2, 1'b0, 1'b0, 5'd1, 5'd3, 5'd7, a, b, c);
    runOp("R5 legal after illegal", 2'd0, 1'b1, 1'b1, 5'd0, 5'd2, 5'd4, a, b, c);
  endtask

  // R8 R9: idle cycles keep outputs and drop valid
  task automatic testHold();
    logic [127:0] held;
    logic heldU;
    runOp("R9 setup", 2'd3, 1'b0, 1'b1, 5'd0, 5'd2, 5'd4, '1, '0, {4{32'h5A5A_A5A5}});
    held = accOut; heldU = undefOut;
    srcA = {4{$urandom}}; srcB = {4{$urandom}}; accIn = {4{$urandom}}; sizeCode = 2'd0;
    @(negedge clk);
    check("R8 idle valid low", 128'(validOut), 128'd0);
    check("R9 acc held", accOut, held);
    check("R9 undef held", 128'(undefOut), 128'(heldU));
  endtask

  initial begin
    testReset();
    testExact();
    testWrap();
    testIllegal();
    testHold();
    testSweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule